// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the current value of an external free-running 16-bit timer when a chosen edge appears on a trigger signal. The trigger is either an external capture pin or the output of an on-chip comparator; one control bit selects which. The selected signal goes through a two-stage synchronizer on the system clock. It then passes an optional glitch filter, which accepts a new level only after four consecutive samples agree on it, and an edge detector whose polarity software chooses. A detected edge copies the timer count into the capture register and raises a capture flag. The flag, gated by an enable bit, forms the interrupt request.

Software reaches the capture register and the flag through a small byte-wide register port. When the capture register serves as the timer's period limit, software writes it one byte at a time. The high byte waits in a holding register, and the whole 16-bit value loads when the low byte arrives. While the timer uses the register as its limit, the filter state and the edge detector are frozen and no capture takes place. Each new capture overwrites the previous one, whether or not software has read it. To measure a duty cycle, software flips the edge polarity after each capture.

The glitch filter is a two-state machine with states FLT_LOW and FLT_HIGH. The transition FLT_LOW to FLT_HIGH fires when the filter is off and the synchronized input is high, or when the filter is on and all four stored samples are high. The transition FLT_HIGH to FLT_LOW is the mirror image of that rule. While capture is disabled, the machine holds its state. Otherwise, when neither condition holds, it stays where it is.

Top module: `tcap_unit`

## Requirements
- R1: While reset is asserted, the capture register, the holding byte and the flag are zero, so every register address reads 0 and `irq` is 0.
- R2: With `src_cmp`=0 the trigger is `pin_in`, and with `src_cmp`=1 it is `cmp_in`. Activity on the input that is not selected has no effect on the capture register or the flag.
- R3: Changing `src_cmp` while the two inputs differ in level acts as a trigger edge and can produce a capture, with the same latency as a change on the trigger input.
- R4: With `rise_edge`=1 only a low-to-high trigger transition captures, and with `rise_edge`=0 only a high-to-low one does. The opposite transition leaves the register and the flag unchanged.
- R5: Suppose the trigger changes between clock edges and the first rising clock edge after the change is edge n. The capture register then receives the `cnt_in` value sampled at edge n+3 when `nc_en`=0, and at edge n+7 when `nc_en`=1.
- R6: With `nc_en`=1, a trigger level held for fewer than 4 clock samples is ignored, with no capture and no flag. A level held for 4 or more samples is accepted.
- R7: A second capture overwrites the first, even when the register was not read in between.
- R8: While `top_mode`=1 no capture occurs. A trigger that has returned to its former level before `top_mode` falls produces no capture afterwards either.
- R9: A write to address 1 stores the high byte without changing the capture register. A later write to address 0 loads {stored high byte, written low byte} into it.
- R10: Each capture sets the flag. Writing 1 to bit 0 at address 2 clears it, and writing 0 there has no effect. A capture in the same cycle as a clear leaves the flag set.
- R11: `irq` equals the flag ANDed with `irq_en`.
- R12: Reads return the low capture byte at address 0, the high byte at address 1, and the flag in bit 0 at address 2 with bits 7:1 zero. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | 16 | Current count of the external timer |
| pin_in | input | 1 | External capture pin |
| cmp_in | input | 1 | Comparator output, the alternate trigger |
| src_cmp | input | 1 | Trigger source: 0 pin, 1 comparator |
| nc_en | input | 1 | Glitch filter enable |
| rise_edge | input | 1 | Edge polarity: 1 rising, 0 falling |
| top_mode | input | 1 | Capture register is the timer limit; capture disabled |
| irq_en | input | 1 | Interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq | output | 1 | Capture interrupt request |

## Verification
The hardest case to reach is the exact boundary of the glitch filter: a pulse must last 3 or 4 samples to land on either side of the threshold. A clear must also arrive in the very cycle a capture loads. The stimulus meets the boundary by running trials in which each pulse width, from 1 to 7 cycles, is known to the bench. Two directed trials use widths 3 and 4. For the collision, the bench drives the flag clear exactly three cycles after a trigger change, so the write is sampled on the same clock edge as the capture. Randomized noise on the input that is not selected shows that the source multiplexer blocks it.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_state_t;

    localparam logic [1:0] ADDR_LO = 2'd0;
    localparam logic [1:0] ADDR_HI = 2'd1;
    localparam logic [1:0] ADDR_ST = 2'd2;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter
    import tcap_pkg::*;
#(
    parameter int NC_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic nc_en,
    input  logic din,
    output logic lvl
);
    flt_state_t        state_q, state_d;
    logic [NC_LEN-1:0] hist_q;
    logic              go_high, go_low;

    // Sample history keeps shifting on every system clock cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[NC_LEN-2:0], din};
    end

    always_comb begin
        go_high = nc_en ? (&hist_q)  : din;
        go_low  = nc_en ? ~(|hist_q) : ~din;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_LOW;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (!hold) begin
            unique case (state_q)
                FLT_LOW:  if (go_high) state_d = FLT_HIGH;
                FLT_HIGH: if (go_low)  state_d = FLT_LOW;
            endcase
        end
    end

    // Outputs
    always_comb begin
        lvl = (state_q == FLT_HIGH);
    end
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic rise,
    input  logic lvl,
    output logic evt
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     prev_q <= 1'b0;
        else if (!hold) prev_q <= lvl;
    end

    always_comb begin
        if (hold)      evt = 1'b0;
        else if (rise) evt = lvl & ~prev_q;
        else           evt = ~lvl & prev_q;
    end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int NC_LEN      = 4,
    localparam int CNT_W      = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             pin_in,
    input  logic             cmp_in,
    input  logic             src_cmp,
    input  logic             nc_en,
    input  logic             rise_edge,
    input  logic             top_mode,
    input  logic             irq_en,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);
    logic             trig_raw;
    logic             sync_q;
    logic             flt_lvl;
    logic             cap_evt;
    logic [CNT_W-1:0] cap_q;
    logic [BUS_W-1:0] hi_tmp_q;
    logic             flag_q;
    logic             wr_lo, wr_hi, wr_clr;

    assign trig_raw = src_cmp ? cmp_in : pin_in;

    tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (trig_raw),
        .q     (sync_q)
    );

    tcap_filter #(.NC_LEN(NC_LEN)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (top_mode),
        .nc_en (nc_en),
        .din   (sync_q),
        .lvl   (flt_lvl)
    );

    tcap_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (top_mode),
        .rise  (rise_edge),
        .lvl   (flt_lvl),
        .evt   (cap_evt)
    );

    assign wr_lo  = bus_wr && (bus_addr == ADDR_LO);
    assign wr_hi  = bus_wr && (bus_addr == ADDR_HI);
    assign wr_clr = bus_wr && (bus_addr == ADDR_ST) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_tmp_q <= '0;
        else if (wr_hi) hi_tmp_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt_in;
        else if (wr_lo)   cap_q <= {hi_tmp_q, bus_wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (cap_evt) flag_q <= 1'b1;
        else if (wr_clr)  flag_q <= 1'b0;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_LO: bus_rdata = cap_q[BUS_W-1:0];
            ADDR_HI: bus_rdata = cap_q[CNT_W-1:BUS_W];
            ADDR_ST: bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
            default: bus_rdata = '0;
        endcase
    end

    assign irq = flag_q & irq_en;
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             top_mode,
    input logic             nc_en,
    input logic             irq_en,
    input logic             irq,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] cap_q,
    input logic             flag_q,
    input logic             cap_evt,
    input logic             sync_q,
    input logic             flt_lvl
);
    // R8
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && !(bus_wr && bus_addr == ADDR_LO)) |=> $stable(cap_q));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag_q);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_ST && bus_wdata[0] && !cap_evt) |=> !flag_q);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R6
    filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nc_en) && $rose(flt_lvl)) |->
            ($past(sync_q, 2) && $past(sync_q, 3) && $past(sync_q, 4) && $past(sync_q, 5)));
endmodule

bind tcap_unit tcap_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .top_mode  (top_mode),
    .nc_en     (nc_en),
    .irq_en    (irq_en),
    .irq       (irq),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cap_q     (cap_q),
    .flag_q    (flag_q),
    .cap_evt   (cap_evt),
    .sync_q    (sync_q),
    .flt_lvl   (flt_lvl)
);

// File: tb/tcap_unit_test.sv
module tcap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_in;
    logic        pin_in, cmp_in, src_cmp, nc_en, rise_edge, top_mode, irq_en;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        irq;

    int          n_checks = 0;
    int          n_errs   = 0;
    bit          done     = 0;
    bit          noise_on = 0;
    logic [15:0] base;
    logic [15:0] tick;

    tcap_unit uut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .pin_in(pin_in), .cmp_in(cmp_in),
        .src_cmp(src_cmp), .nc_en(nc_en), .rise_edge(rise_edge), .top_mode(top_mode),
        .irq_en(irq_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: everything changes just after the falling edge.
    task automatic step();
        @(negedge clk);
        tick   = tick + 16'd1;
        cnt_in = base + tick;
        if (noise_on) begin
            if (src_cmp) pin_in = 1'($urandom);
            else         cmp_in = 1'($urandom);
        end
    endtask

    task automatic set_trig(input bit v);
        if (src_cmp) cmp_in = v;
        else         pin_in = v;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_cap(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic read_flag(output logic f);
        logic [7:0] s;
        bus_read(2'd2, s);
        f = s[0];
    endtask

    function automatic logic [15:0] exp_cap(input bit lvl0, input bit rise, input bit nc,
                                            input int w, input logic [15:0] old,
                                            input logic [15:0] t0, input logic [15:0] t1);
        logic [15:0] dly = nc ? 16'd7 : 16'd3;
        if (nc && w < 4)         return old;
        if (rise == (lvl0 == 0)) return base + t0 + dly;
        return base + t1 + dly;
    endfunction

    task automatic settle_and_clear(input bit src, input bit lvl0);
        src_cmp = src;
        set_trig(lvl0);
        repeat (12) step();
        bus_write(2'd2, 8'h01);
    endtask

    // Pulse trial: level lvl0, then the opposite for w cycles, then back.
    task automatic trial(input bit lvl0, input bit rise, input bit nc, input bit src,
                         input int w, input bit ien, input string tag);
        logic [15:0] old, got, exp, t0, t1;
        logic        f, exp_f;
        rise_edge = rise; nc_en = nc; irq_en = ien;
        settle_and_clear(src, lvl0);
        read_cap(old);
        step();
        set_trig(!lvl0); t0 = tick;
        repeat (w) step();
        set_trig(lvl0); t1 = tick;
        repeat (16) step();
        exp   = exp_cap(lvl0, rise, nc, w, old, t0, t1);
        exp_f = !(nc && w < 4);
        read_cap(got);
        chk(got == exp, tag, "capture value (R4 R5 R6 R2)", got, exp);
        read_flag(f);
        chk(f == exp_f, tag, "flag (R10)", f, exp_f);
        chk(irq == (exp_f && ien), "R11", "irq", irq, exp_f && ien);
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] v, t0, t1;
        logic        f;
        void'($urandom(32'd20240611));
        base = 16'($urandom);
        tick = 0; cnt_in = base;
        rst_n = 0; pin_in = 0; cmp_in = 0; src_cmp = 0; nc_en = 0; rise_edge = 1;
        top_mode = 0; irq_en = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        repeat (5) step();
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), b);
            chk(b == 8'h00, "R1", "reset read", b, 0);
        end
        chk(irq == 1'b0, "R1", "reset irq", irq, 0);
        rst_n = 1;
        repeat (3) step();

        // R9: byte writes
        bus_write(2'd1, 8'hBE);
        bus_read(2'd1, b);
        chk(b == 8'h00, "R9", "high byte alone", b, 0);
        bus_write(2'd0, 8'hEF);
        read_cap(v);
        chk(v == 16'hBEEF, "R9", "16-bit load", v, 16'hBEEF);
        // R12: read map
        bus_read(2'd3, b);
        chk(b == 8'h00, "R12", "address 3", b, 0);
        bus_read(2'd0, b);
        chk(b == 8'hEF, "R12", "low byte at 0", b, 8'hEF);

        // R3: source switch with differing levels
        noise_on = 0; nc_en = 0; rise_edge = 1; irq_en = 0;
        pin_in = 0; cmp_in = 1;
        settle_and_clear(1'b0, 1'b0);
        step();
        src_cmp = 1; t0 = tick;
        repeat (10) step();
        read_cap(v);
        chk(v == base + t0 + 16'd3, "R3", "switch capture", v, base + t0 + 16'd3);
        read_flag(f);
        chk(f == 1'b1, "R3", "switch flag", f, 1);

        // R8: no capture while the register is the timer limit
        noise_on = 1;
        settle_and_clear(1'b0, 1'b0);
        read_cap(t1);
        top_mode = 1;
        step();
        set_trig(1); repeat (5) step();
        set_trig(0); repeat (6) step();
        top_mode = 0;
        repeat (10) step();
        read_cap(v);
        chk(v == t1, "R8", "capture value held", v, t1);
        read_flag(f);
        chk(f == 1'b0, "R8", "no flag", f, 0);

        // R7: overwrite without reading
        settle_and_clear(1'b0, 1'b0);
        step(); set_trig(1);
        repeat (3) step(); set_trig(0);
        repeat (3) step(); set_trig(1); t1 = tick;
        repeat (10) step();
        read_cap(v);
        chk(v == base + t1 + 16'd3, "R7", "second capture", v, base + t1 + 16'd3);

        // R10: clear collides with capture, then write 0, then write 1
        settle_and_clear(1'b0, 1'b0);
        step(); set_trig(1);
        repeat (3) step();
        bus_write(2'd2, 8'h01);
        repeat (2) step();
        read_flag(f);
        chk(f == 1'b1, "R10", "set beats clear", f, 1);
        bus_write(2'd2, 8'hFE);
        read_flag(f);
        chk(f == 1'b1, "R10", "write 0 ignored", f, 1);
        bus_write(2'd2, 8'h01);
        read_flag(f);
        chk(f == 1'b0, "R10", "write 1 clears", f, 0);
        bus_read(2'd2, b);
        chk(b[7:1] == 7'd0, "R12", "status upper bits", b, 0);

        // R6: filter boundary widths
        trial(1'b0, 1'b1, 1'b1, 1'b0, 3, 1'b1, "R6");
        trial(1'b0, 1'b1, 1'b1, 1'b0, 4, 1'b1, "R6");
        trial(1'b1, 1'b0, 1'b1, 1'b1, 3, 1'b0, "R6");
        // R4: opposite polarity selects the return edge
        trial(1'b0, 1'b0, 1'b0, 1'b0, 5, 1'b1, "R4");
        // R5: both latencies
        trial(1'b1, 1'b0, 1'b0, 1'b1, 6, 1'b1, "R5");
        trial(1'b1, 1'b0, 1'b1, 1'b0, 6, 1'b1, "R5");

        // Random trials; the unselected input is noise (R2)
        for (int i = 0; i < 40; i++) begin
            trial(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1 + int'($urandom % 7), 1'($urandom), "R2");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule